// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory channel. It owns the command bus from reset until the attached device is ready to use. While the supply is coming up it keeps the clock-enable line low, which keeps the device outputs disabled, and it drives only no-operation commands. When both the power-good and clock-stable inputs are high, it waits a long, parameterised hold time. The default count corresponds to 200 µs at a 400 MHz controller clock. It then raises clock-enable and steps through a fixed sequence: a precharge of all banks, a programmable number of auto-refresh commands (two or more), a write to the main mode register and a write to the extended mode register.

Every gap between commands is filled with no-operation cycles. Each gap is timed by one shared loadable down-counter, with lengths given in clock cycles. The sequencer forces the normal operating-mode bit of the main mode word to zero and the DLL-disable bit of the extended word to zero, so the DLL is enabled whatever value the caller supplies. After the last mode-register delay has run out, the ready flag rises. Downstream command logic then takes the bus. If power-good falls at any time, clock-enable and the ready flag drop on the next cycle and the whole sequence starts again from the clock-enable-low state. The on-die termination control is held low throughout.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted and in the first cycles after it, cke is 0, the command bus carries NOP, ba and addr are 0, and init_done is 0.
- R2: cke stays 0 until pwr_ok and clk_ok have both been sampled high. It rises exactly T_STABLE_CYC+1 cycles after the first rising clock edge that samples both high, and it never rises earlier.
- R3: Commands use the encoding {cs_n,ras_n,cas_n,we_n}: NOP=0111, PRECHARGE=0010, REFRESH=0001, LOAD MODE=0000. Every cycle that carries none of the sequence commands shows NOP with ba=0 and addr=0, and no command other than NOP appears while cke is 0.
- R4: The precharge-all command appears exactly T_CKE_CYC cycles after cke rises, with addr bit 10 set, all other address bits 0 and ba=0.
- R5: Exactly NUM_REF REFRESH commands follow. The first comes T_RP_CYC cycles after the precharge and each later one comes T_RFC_CYC cycles after the previous one. cke is 1 at each of them.
- R6: A LOAD MODE with ba=0 comes T_RFC_CYC cycles after the last REFRESH. Its addr equals mr_value with bit 7 forced to 0.
- R7: A LOAD MODE with ba=1 comes exactly T_MRD_CYC cycles after the main one. Its addr equals emr_value with bit 0 forced to 0, which enables the DLL.
- R8: init_done rises T_MRD_CYC cycles after the extended LOAD MODE and then stays high with the bus at NOP for as long as pwr_ok stays high.
- R9: If pwr_ok is sampled low in any state, the next cycle shows cke=0, init_done=0 and NOP. A later return of pwr_ok and clk_ok restarts the full sequence from the beginning with the same timing.
- R10: odt is 0 in every cycle.
- R11: With only one of pwr_ok and clk_ok high, the sequencer stays idle: cke remains 0 and only NOP is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_ok | input | 1 | Supply is within range |
| clk_ok | input | 1 | Device clock is running and stable |
| mr_value | input | ADDR_W | Word for the main mode register (bit 7 is overridden) |
| emr_value | input | ADDR_W | Word for the extended mode register (bit 0 is overridden) |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| odt | output | 1 | Termination control, always low |
| init_done | output | 1 | Sequence finished, bus may be handed over |

## Verification
The assertions watch invariants on every cycle. A refresh never appears without clock-enable and a precharge always carries bit 10. The two mode words always carry their forced bits, the ready flag is sticky and quiet, and a power loss clears clock-enable on the next cycle. The sequencer state only moves forward one step or back to idle, and the refresh count stays within bounds. The exact spacing between commands, the length of the clock-enable-low hold and the full order of the sequence can only be shown by the bench. It compares every cycle of a complete run against a schedule it works out from the wait parameters. It also drops power-good at every cycle position of the sequence and checks that the restart reproduces that schedule.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } cmd_e;

    // order matters: the sequence only advances by one step or returns to ST_OFF
    typedef enum logic [2:0] {
        ST_OFF      = 3'd0,
        ST_HOLD     = 3'd1,
        ST_CKE_WAIT = 3'd2,
        ST_PRE_WAIT = 3'd3,
        ST_REF_WAIT = 3'd4,
        ST_MR_WAIT  = 3'd5,
        ST_EMR_WAIT = 3'd6,
        ST_DONE     = 3'd7
    } seq_state_e;

    localparam int ALL_BANKS_BIT = 10;
    localparam int OPMODE_BIT    = 7;
    localparam int DLL_OFF_BIT   = 0;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.cnt = load_val_i;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign expired_o = (r_q.cnt == '0);

    // an idle counter must not wrap around (gap lengths in R4..R8)
    p_timer_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && expired_o) |=> expired_o);

endmodule

// File: rtl/ddr2_init_fsm.sv
module ddr2_init_fsm
    import ddr2_init_pkg::*;
#(
    parameter int T_STABLE_CYC = 80000,
    parameter int T_CKE_CYC    = 160,
    parameter int T_RP_CYC     = 5,
    parameter int T_RFC_CYC    = 42,
    parameter int T_MRD_CYC    = 2,
    parameter int NUM_REF      = 2,
    parameter int CNT_W        = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_ok_i,
    input  logic             clk_ok_i,
    input  logic             expired_i,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             cke_o,
    output cmd_e             cmd_o,
    output logic             emr_sel_o,
    output logic             done_o
);

    localparam int RC_W = $clog2(NUM_REF + 1);

    // a command at cycle c with load value L lets the next one appear at c + L + 1
    localparam logic [CNT_W-1:0] LD_STABLE = CNT_W'(T_STABLE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_CKE    = CNT_W'(T_CKE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RP     = CNT_W'(T_RP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RFC    = CNT_W'(T_RFC_CYC - 1);
    localparam logic [CNT_W-1:0] LD_MRD    = CNT_W'(T_MRD_CYC - 1);
    localparam logic [RC_W-1:0]  REF_LAST  = RC_W'(NUM_REF);

    typedef struct packed {
        seq_state_e      st;
        logic [RC_W-1:0] refs;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        load_o     = 1'b0;
        load_val_o = '0;
        cke_o      = (r_q.st != ST_OFF) && (r_q.st != ST_HOLD);
        cmd_o      = CMD_NOP;
        emr_sel_o  = 1'b0;
        done_o     = (r_q.st == ST_DONE);

        if (!pwr_ok_i) begin
            r_d.st   = ST_OFF;
            r_d.refs = '0;
            cke_o    = 1'b0;
            done_o   = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_OFF: begin
                    if (clk_ok_i) begin
                        load_o     = 1'b1;
                        load_val_o = LD_STABLE;
                        r_d.st     = ST_HOLD;
                    end
                end
                ST_HOLD: begin
                    if (expired_i) begin
                        cke_o      = 1'b1;
                        load_o     = 1'b1;
                        load_val_o = LD_CKE;
                        r_d.st     = ST_CKE_WAIT;
                    end
                end
                ST_CKE_WAIT: begin
                    if (expired_i) begin
                        cmd_o      = CMD_PRE;
                        load_o     = 1'b1;
                        load_val_o = LD_RP;
                        r_d.st     = ST_PRE_WAIT;
                    end
                end
                ST_PRE_WAIT: begin
                    if (expired_i) begin
                        cmd_o      = CMD_REF;
                        load_o     = 1'b1;
                        load_val_o = LD_RFC;
                        r_d.refs   = RC_W'(1);
                        r_d.st     = ST_REF_WAIT;
                    end
                end
                ST_REF_WAIT: begin
                    if (expired_i) begin
                        load_o = 1'b1;
                        if (r_q.refs < REF_LAST) begin
                            cmd_o      = CMD_REF;
                            load_val_o = LD_RFC;
                            r_d.refs   = r_q.refs + RC_W'(1);
                        end else begin
                            cmd_o      = CMD_LMR;
                            load_val_o = LD_MRD;
                            r_d.st     = ST_MR_WAIT;
                        end
                    end
                end
                ST_MR_WAIT: begin
                    if (expired_i) begin
                        cmd_o      = CMD_LMR;
                        emr_sel_o  = 1'b1;
                        load_o     = 1'b1;
                        load_val_o = LD_MRD;
                        r_d.st     = ST_EMR_WAIT;
                    end
                end
                ST_EMR_WAIT: begin
                    if (expired_i) begin
                        done_o = 1'b1;
                        r_d.st = ST_DONE;
                    end
                end
                ST_DONE: begin
                end
                default: begin
                    r_d.st = ST_OFF;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_OFF;
            r_q.refs <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // sequence order fixed: advance one step or restart (R9)
    p_step_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != $past(r_q.st)) |->
            ((r_q.st == ST_OFF) || (3'(r_q.st) == 3'($past(r_q.st)) + 3'd1)));

    // refresh count never passes the configured number (R5)
    p_ref_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.refs <= REF_LAST);

    // mode registers only after all refreshes (R6)
    p_mr_after_refs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MR_WAIT) |-> (r_q.refs == REF_LAST));

endmodule

// File: rtl/ddr2_init_cmd_drv.sv
module ddr2_init_cmd_drv
    import ddr2_init_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_i,
    input  cmd_e              cmd_i,
    input  logic              emr_sel_i,
    input  logic              done_i,
    input  logic [ADDR_W-1:0] mr_value_i,
    input  logic [ADDR_W-1:0] emr_value_i,
    output logic              cke_o,
    output cmd_e              cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o
);

    localparam logic [ADDR_W-1:0] PRE_ALL_WORD = ADDR_W'(1) << ALL_BANKS_BIT;
    localparam logic [ADDR_W-1:0] MR_KEEP      = ~(ADDR_W'(1) << OPMODE_BIT);
    localparam logic [ADDR_W-1:0] EMR_KEEP     = ~(ADDR_W'(1) << DLL_OFF_BIT);

    typedef struct packed {
        logic              cke;
        cmd_e              cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } bus_regs_t;

    bus_regs_t r_d, r_q;

    always_comb begin
        r_d.cke  = cke_i;
        r_d.cmd  = cmd_i;
        r_d.done = done_i;
        r_d.ba   = '0;
        r_d.addr = '0;
        unique case (cmd_i)
            CMD_PRE: r_d.addr = PRE_ALL_WORD;
            CMD_LMR: begin
                if (emr_sel_i) begin
                    r_d.ba   = BA_W'(1);
                    r_d.addr = emr_value_i & EMR_KEEP;
                end else begin
                    r_d.addr = mr_value_i & MR_KEEP;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.cke  <= 1'b0;
            r_q.cmd  <= CMD_NOP;
            r_q.ba   <= '0;
            r_q.addr <= '0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cke_o  = r_q.cke;
    assign cmd_o  = r_q.cmd;
    assign ba_o   = r_q.ba;
    assign addr_o = r_q.addr;
    assign done_o = r_q.done;

    p_cmd_needs_cke_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd != CMD_NOP) |-> r_q.cke);

    p_pre_all_banks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_PRE) |-> r_q.addr[ALL_BANKS_BIT]);

    p_ref_cke_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_REF) |-> (r_q.cke && $past(r_q.cke)));

    p_mr_normal_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_LMR && r_q.ba == '0) |-> !r_q.addr[OPMODE_BIT]);

    p_emr_dll_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.cmd == CMD_LMR && r_q.ba == BA_W'(1)) |-> !r_q.addr[DLL_OFF_BIT]);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (r_q.cmd == CMD_NOP && r_q.cke));

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int T_STABLE_CYC = 80000,
    parameter int T_CKE_CYC    = 160,
    parameter int T_RP_CYC     = 5,
    parameter int T_RFC_CYC    = 42,
    parameter int T_MRD_CYC    = 2,
    parameter int NUM_REF      = 2,
    parameter int ADDR_W       = 14,
    parameter int BA_W         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              clk_ok,
    input  logic [ADDR_W-1:0] mr_value,
    input  logic [ADDR_W-1:0] emr_value,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              odt,
    output logic              init_done
);

    localparam int MAX_WAIT = max_of(max_of(T_STABLE_CYC, T_CKE_CYC),
                                     max_of(max_of(T_RP_CYC, T_RFC_CYC), T_MRD_CYC));
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             req_cke;
    cmd_e             req_cmd;
    logic             req_emr;
    logic             req_done;
    cmd_e             bus_cmd;

    ddr2_init_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    ddr2_init_fsm #(
        .T_STABLE_CYC (T_STABLE_CYC),
        .T_CKE_CYC    (T_CKE_CYC),
        .T_RP_CYC     (T_RP_CYC),
        .T_RFC_CYC    (T_RFC_CYC),
        .T_MRD_CYC    (T_MRD_CYC),
        .NUM_REF      (NUM_REF),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_ok_i   (pwr_ok),
        .clk_ok_i   (clk_ok),
        .expired_i  (tmr_expired),
        .load_o     (tmr_load),
        .load_val_o (tmr_val),
        .cke_o      (req_cke),
        .cmd_o      (req_cmd),
        .emr_sel_o  (req_emr),
        .done_o     (req_done)
    );

    ddr2_init_cmd_drv #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_drv (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke_i       (req_cke),
        .cmd_i       (req_cmd),
        .emr_sel_i   (req_emr),
        .done_i      (req_done),
        .mr_value_i  (mr_value),
        .emr_value_i (emr_value),
        .cke_o       (cke),
        .cmd_o       (bus_cmd),
        .ba_o        (ba),
        .addr_o      (addr),
        .done_o      (init_done)
    );

    assign {cs_n, ras_n, cas_n, we_n} = bus_cmd;
    assign odt = 1'b0;

    // power loss clears the bus on the next cycle
    p_power_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (!cke && !init_done && {cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // ready flag is sticky while power stays good
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && pwr_ok) |=> init_done);

    // clock enable, once up, stays up while power is good
    p_cke_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && pwr_ok) |=> cke);

endmodule

// File: tb/ddr2_init_seq_bench.sv
module ddr2_init_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TS   = 20;
    localparam int TC   = 5;
    localparam int TRP  = 3;
    localparam int TRFC = 7;
    localparam int TMRD = 2;
    localparam int NREF = 3;
    localparam int AW   = 14;
    localparam int BW   = 2;

    localparam int K_CKE  = TS + 1;
    localparam int K_PRE  = K_CKE + TC;
    localparam int K_REF0 = K_PRE + TRP;
    localparam int K_MR   = K_REF0 + NREF * TRFC;
    localparam int K_EMR  = K_MR + TMRD;
    localparam int K_DONE = K_EMR + TMRD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_ok = 1'b0;
    logic          clk_ok = 1'b0;
    logic [AW-1:0] mr_value = '0;
    logic [AW-1:0] emr_value = '0;
    logic          cke, cs_n, ras_n, cas_n, we_n, odt, init_done;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr2_init_seq #(
        .T_STABLE_CYC (TS),
        .T_CKE_CYC    (TC),
        .T_RP_CYC     (TRP),
        .T_RFC_CYC    (TRFC),
        .T_MRD_CYC    (TMRD),
        .NUM_REF      (NREF),
        .ADDR_W       (AW),
        .BA_W         (BW)
    ) u_ddr2_init_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_ok    (pwr_ok),
        .clk_ok    (clk_ok),
        .mr_value  (mr_value),
        .emr_value (emr_value),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ba        (ba),
        .addr      (addr),
        .odt       (odt),
        .init_done (init_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // bus must be idle: cke low, NOP, zero address, not done, odt low
    task automatic chk_idle(input string req);
        chk(cke == 1'b0, req, 32'(cke), 0);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, req, 32'({cs_n, ras_n, cas_n, we_n}), 32'h7);
        chk(ba == '0 && addr == '0, req, 32'({ba, addr}), 0);
        chk(init_done == 1'b0, req, 32'(init_done), 0);
        chk(odt == 1'b0, "R10", 32'(odt), 0);
    endtask

    // expected bus in sample k (k=1 is the first cycle after both inputs are seen high)
    task automatic chk_step(input int k);
        logic [3:0]    e_cmd;
        logic [BW-1:0] e_ba;
        logic [AW-1:0] e_addr;
        string         tag;
        e_cmd  = 4'b0111;
        e_ba   = '0;
        e_addr = '0;
        tag    = "R3";
        if (k == K_PRE) begin
            e_cmd = 4'b0010; e_addr = AW'(1) << 10; tag = "R4";
        end else if (k >= K_REF0 && k < K_MR && ((k - K_REF0) % TRFC) == 0) begin
            e_cmd = 4'b0001; tag = "R5";
        end else if (k == K_MR) begin
            e_cmd = 4'b0000; e_addr = mr_value & ~(AW'(1) << 7); tag = "R6";
        end else if (k == K_EMR) begin
            e_cmd = 4'b0000; e_ba = BW'(1); e_addr = emr_value & ~AW'(1); tag = "R7";
        end
        chk(cke == (k >= K_CKE), "R2", 32'(cke), 32'(k >= K_CKE));
        chk({cs_n, ras_n, cas_n, we_n} == e_cmd, tag, 32'({cs_n, ras_n, cas_n, we_n}), 32'(e_cmd));
        chk(ba == e_ba, tag, 32'(ba), 32'(e_ba));
        chk(addr == e_addr, tag, 32'(addr), 32'(e_addr));
        chk(init_done == (k >= K_DONE), "R8", 32'(init_done), 32'(k >= K_DONE));
        chk(odt == 1'b0, "R10", 32'(odt), 0);
    endtask

    // called just after a negedge with the design idle; stop_at=0 runs to the end
    task automatic run_seq(input logic [AW-1:0] mv, input logic [AW-1:0] ev, input int stop_at);
        mr_value  = mv;
        emr_value = ev;
        pwr_ok    = 1'b1;
        clk_ok    = 1'b1;
        for (int k = 1; k <= K_DONE + 3; k++) begin
            @(negedge clk);
            chk_step(k);
            if (k == stop_at) return;
        end
    endtask

    task automatic power_off();
        pwr_ok = 1'b0;
        clk_ok = 1'b0;
        @(negedge clk);
        chk_idle("R9");
        @(negedge clk);
        chk_idle("R9");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");

        // R11: only one of the two qualifying inputs high
        pwr_ok = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk_idle("R11");
        end
        pwr_ok = 1'b0;
        clk_ok = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk_idle("R11");
        end
        clk_ok = 1'b0;
        @(negedge clk);

        // full runs with several mode words (R2..R8, R10)
        run_seq(14'h3FFF, 14'h3FFF, 0);
        power_off();
        run_seq(14'h0000, 14'h0000, 0);
        power_off();
        run_seq(14'h0A53, 14'h1C81, 0);
        // hold the done state for a while (R8)
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(init_done == 1'b1 && {cs_n, ras_n, cas_n, we_n} == 4'b0111 && cke == 1'b1,
                "R8", 32'({init_done, cs_n, ras_n, cas_n, we_n, cke}), 32'h3F);
        end
        power_off();

        // R9: power loss at every position, then a clean restart
        for (int d = 1; d <= K_DONE + 2; d++) begin
            run_seq(AW'(d * 37), AW'(d * 91), d);
            power_off();
            run_seq(14'h2D6B, 14'h0F0F, 0);
            power_off();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule